// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns a single asynchronous serial line, which rests high between characters, into parallel characters. A high-to-low transition marks a start bit. The receiver confirms that start bit half a bit time later, then samples every later bit in the middle of its bit period. Timing comes from a 16x oversampling tick that a programmable clock divisor produces. The receiver does not search for the stop bit. It counts bits at the agreed rate, so the stop position follows from the configured frame shape.

At run time the user selects 5 to 8 data bits, whether a parity bit is present and whether it is odd or even, a stop interval of 1, 1.5 or 2 bit times, and the divisor. Each received character appears on the data output together with a one-clock valid strobe, a parity-error flag and a framing-error flag. The configuration inputs must not change while a character is in flight.

Top module: `async_rx`

## Requirements
- R1: During and after reset, before any character arrives, `valid_o`, `data_o`, `par_err_o` and `frame_err_o` are all zero and the receiver waits for a start bit.
- R2: `valid_o` is high for exactly one clock. It rises in the cycle after clock edge number 2 + (8 + 16·n)·D, where D is `div_i`, counting from the first edge that samples `rx_i` low, and n = data bits + 1 if parity is enabled + 1.
- R3: If `rx_i` is high again at the half-bit check of the start bit (8 ticks after detection), the receiver returns to waiting, produces no character, and accepts the next proper character normally.
- R4: `data_len_i` selects 5, 6, 7 or 8 data bits for codes 0, 1, 2 and 3. Bits are assembled least-significant first, and the bits of `data_o` above the selected length are zero.
- R5: With `par_en_i` = 1, one parity bit follows the last data bit and never enters `data_o`. `par_err_o` is 1 when the XOR of the data bits and the parity bit differs from `par_odd_i` (1 = odd, 0 = even). With `par_en_i` = 0, `par_err_o` is 0.
- R6: `frame_err_o` is 1 when `rx_i` is low at the first stop sample. The character is still delivered with its data and parity result.
- R7: After a framing error the receiver ignores a low line and arms for a new start bit only once it has seen `rx_i` high.
- R8: `stop_len_i` codes 0, 1 and 2/3 select 1, 1.5 and 2 stop bits. After the first stop sample the line is ignored for 0, 8 or 16 ticks. After that the receiver is armed, so a character that starts right after the stop interval is received intact.
- R9: One tick spans `div_i` clocks (`div_i` ≥ 1), and one bit spans 16 ticks.
- R10: `data_o`, `par_err_o` and `frame_err_o` hold their values until the next `valid_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idles high |
| data_len_i | input | 2 | Data length code: 0..3 = 5..8 bits |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| stop_len_i | input | 2 | Stop length code: 0 = 1, 1 = 1.5, 2/3 = 2 bits |
| div_i | input | DIV_W | Clocks per oversampling tick, at least 1 |
| data_o | output | 8 | Received character, LSB first, upper bits zero |
| valid_o | output | 1 | One-clock strobe for a new character |
| par_err_o | output | 1 | Parity check failed for this character |
| frame_err_o | output | 1 | Line low at the first stop sample |

## Verification
The embedded properties check, on every cycle, that the strobe lasts one clock, that unused data bits are zero, that parity errors stay off when parity is disabled, and that a framing error leads to the wait-for-high state and stays there while the line is low. They also check that the line is ignored during the stop hold and that ticks are spaced by the divisor. Only the bench scenarios can show exact sample placement, correct bit order across lengths and divisors, false-start rejection, and the effect of stop length on back-to-back characters. The bench compares these every clock against an arithmetic timing model of the line.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD, ST_WAIT
  } rx_state_e;

  localparam int unsigned OVS = 16;

  function automatic logic [3:0] data_bits(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

  function automatic logic [4:0] hold_ticks(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd0;
      2'd1:    return 5'd8;
      default: return 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/async_rx_sync.sv
module async_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q[i] <= 1'b1;
        else         sr_q[i] <= (i == 0) ? d_i : sr_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/async_rx_tick.sv
module async_rx_tick #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;

  assign tick_o = en_i && (pre_q == div_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (!en_i)   pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end

  // R9
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i > 1) |=> !tick_o);
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
  import async_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  input  logic       tick_i,
  input  logic [1:0] data_len_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic [1:0] stop_len_i,
  output logic       busy_o,
  output logic [7:0] data_o,
  output logic       valid_o,
  output logic       par_err_o,
  output logic       frame_err_o
);
  localparam int unsigned CW = $clog2(OVS);

  rx_state_e   state_q;
  logic [CW-1:0] tcnt_q;
  logic [2:0]  idx_q;
  logic [7:0]  acc_q;
  logic        pbit_q;
  logic [3:0]  nbits;
  logic [4:0]  hold;
  logic        mid;

  assign nbits  = data_bits(data_len_i);
  assign hold   = hold_ticks(stop_len_i);
  assign busy_o = (state_q != ST_IDLE) && (state_q != ST_WAIT);
  assign mid    = tick_i && (tcnt_q == CW'(OVS-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      tcnt_q      <= '0;
      idx_q       <= '0;
      acc_q       <= '0;
      pbit_q      <= 1'b0;
      data_o      <= '0;
      valid_o     <= 1'b0;
      par_err_o   <= 1'b0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i) tcnt_q <= tcnt_q + 1'b1;
      case (state_q)
        ST_IDLE: begin
          tcnt_q <= '0;
          if (!line_i) state_q <= ST_START;
        end
        ST_START:
          if (tick_i && tcnt_q == CW'(OVS/2-1)) begin
            tcnt_q <= '0;
            idx_q  <= '0;
            acc_q  <= '0;
            state_q <= line_i ? ST_IDLE : ST_DATA;  // false start
          end
        ST_DATA:
          if (mid) begin
            acc_q[idx_q] <= line_i;
            idx_q <= idx_q + 1'b1;
            if ({1'b0, idx_q} == nbits - 4'd1)
              state_q <= par_en_i ? ST_PAR : ST_STOP;
          end
        ST_PAR:
          if (mid) begin
            pbit_q  <= line_i;
            state_q <= ST_STOP;
          end
        ST_STOP:
          if (mid) begin
            valid_o     <= 1'b1;
            data_o      <= acc_q;
            frame_err_o <= !line_i;
            par_err_o   <= par_en_i && ((^acc_q ^ pbit_q) != par_odd_i);
            if (!line_i)         state_q <= ST_WAIT;
            else if (hold == 0)  state_q <= ST_IDLE;
            else                 state_q <= ST_HOLD;
          end
        ST_HOLD:
          if (tick_i && {1'b0, tcnt_q} == hold - 5'd1) state_q <= ST_IDLE;
        ST_WAIT:
          if (line_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R4
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((16'(data_o) >> nbits) == 16'd0));
  // R5
  par_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !par_en_i) |-> !par_err_o);
  // R6
  ferr_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && frame_err_o) |-> state_q == ST_WAIT);
  // R7
  wait_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !line_i) |=> state_q == ST_WAIT);
  // R8
  hold_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD) |=> state_q != ST_START);
endmodule

// File: rtl/async_rx.sv
module async_rx #(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic [1:0]       data_len_i,
  input  logic             par_en_i,
  input  logic             par_odd_i,
  input  logic [1:0]       stop_len_i,
  input  logic [DIV_W-1:0] div_i,
  output logic [7:0]       data_o,
  output logic             valid_o,
  output logic             par_err_o,
  output logic             frame_err_o
);
  logic line, tick, busy;

  async_rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(line)
  );

  async_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .en_i(busy), .div_i, .tick_o(tick)
  );

  async_rx_core u_core (
    .clk_i, .rst_ni, .line_i(line), .tick_i(tick),
    .data_len_i, .par_en_i, .par_odd_i, .stop_len_i,
    .busy_o(busy), .data_o, .valid_o, .par_err_o, .frame_err_o
  );
endmodule

// File: tb/tb_async_rx.sv
`timescale 1ns/1ps
module tb_async_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic [1:0] len = 2'd3;
  logic       pen = 1'b0, podd = 1'b0;
  logic [1:0] stp = 2'd0;
  logic [15:0] div = 16'd2;
  logic [7:0] data;
  logic       valid, perr, ferr;

  int vectors = 0, errs = 0;

  always #10 clk = ~clk;

  async_rx dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .data_len_i(len),
    .par_en_i(pen), .par_odd_i(podd), .stop_len_i(stp), .div_i(div),
    .data_o(data), .valid_o(valid), .par_err_o(perr), .frame_err_o(ferr)
  );

  // arithmetic timing model: edges counted since start detection
  logic m_s1, m_s2, m_pbit, m_valid, m_perr, m_ferr;
  logic [7:0] m_acc, m_data;
  int m_mode, m_t, tn, k, nb, hd, dv;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_mode <= 0; m_t <= 0;
      m_acc <= '0; m_pbit <= 1'b0; m_valid <= 1'b0;
      m_data <= '0; m_perr <= 1'b0; m_ferr <= 1'b0;
    end else begin
      m_s1 <= rx; m_s2 <= m_s1; m_valid <= 1'b0;
      dv = int'(div); nb = int'(len) + 5;
      hd = (stp == 2'd0) ? 0 : (stp == 2'd1) ? 8 : 16;
      case (m_mode)
        0: if (!m_s2) begin m_mode <= 1; m_t <= 0; end
        1: begin
          tn = m_t + 1; m_t <= tn;
          if (tn == 8*dv) begin
            m_acc <= '0;
            if (m_s2) m_mode <= 0;
          end else if (tn > 8*dv && (tn - 8*dv) % (16*dv) == 0) begin
            k = (tn - 8*dv) / (16*dv);
            if (k <= nb) m_acc[k-1] <= m_s2;
            else if (pen && k == nb + 1) m_pbit <= m_s2;
            else begin
              m_valid <= 1'b1; m_data <= m_acc; m_ferr <= !m_s2;
              m_perr <= pen && ((^m_acc ^ m_pbit) != podd);
              if (!m_s2) m_mode <= 3;
              else if (hd == 0) m_mode <= 0;
              else begin m_mode <= 2; m_t <= 0; end
            end
          end
        end
        2: begin
          m_t <= m_t + 1;
          if (m_t + 1 == hd*dv) m_mode <= 0;
        end
        default: if (m_s2) m_mode <= 0;
      endcase
    end
  end

  int got_cnt = 0;
  logic [7:0] got_data;
  logic got_pe, got_fe;

  always @(negedge clk) if (rst_n) begin
    vectors++;
    if (valid !== m_valid) begin
      errs++; $display("FAIL R2 R8 valid_o act=%b exp=%b t=%0t", valid, m_valid, $time);
    end
    if (data !== m_data) begin
      errs++; $display("FAIL R4 R10 data_o act=%h exp=%h t=%0t", data, m_data, $time);
    end
    if (perr !== m_perr) begin
      errs++; $display("FAIL R5 par_err_o act=%b exp=%b t=%0t", perr, m_perr, $time);
    end
    if (ferr !== m_ferr) begin
      errs++; $display("FAIL R6 frame_err_o act=%b exp=%b t=%0t", ferr, m_ferr, $time);
    end
    if (valid) begin got_cnt++; got_data = data; got_pe = perr; got_fe = ferr; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++; $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n * int'(div)) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] b, input bit bad_par, input int stop_half,
                      input bit bad_stop);
    int n = int'(len) + 5;
    logic p = ^(b & ((8'd1 << n) - 8'd1)) ^ podd;
    @(posedge clk); #1;
    rx = 1'b0; ticks(16);
    for (int i = 0; i < n; i++) begin rx = b[i]; ticks(16); end
    if (pen) begin rx = p ^ bad_par; ticks(16); end
    rx = !bad_stop; ticks(8 * stop_half);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; $display("FAIL watchdog expired");
    summary();
  end

  int c0;
  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid", valid, 0); chk("R1 data", data, 0);
    chk("R1 perr", perr, 0);   chk("R1 ferr", ferr, 0);
    rst_n = 1'b1;
    repeat (40) @(posedge clk);
    #1;
    chk("R1 idle no strobe", got_cnt, 0);

    // 8N1, D=2
    c0 = got_cnt; send(8'hA5, 0, 2, 0); ticks(4);
    chk("R2 one char", got_cnt, c0 + 1); chk("R4 data 8N1", got_data, 8'hA5);
    chk("R5 no perr", got_pe, 0); chk("R6 no ferr", got_fe, 0);

    // 7E1, D=3 (R9)
    div = 16'd3; len = 2'd2; pen = 1; podd = 0;
    send(8'h5A, 0, 2, 0); ticks(4);
    chk("R9 data 7E1 div3", got_data, 8'h5A); chk("R5 good even", got_pe, 0);

    // 5O2, D=1, upper bits zero
    div = 16'd1; len = 2'd0; podd = 1; stp = 2'd2;
    send(8'hF3, 0, 4, 0); ticks(4);
    chk("R4 5-bit upper zero", got_data, 8'h13); chk("R5 good odd", got_pe, 0);

    // bad parity
    send(8'h0C, 1, 4, 0); ticks(4);
    chk("R5 parity error", got_pe, 1); chk("R5 data kept", got_data, 8'h0C);

    // framing error, 6 bits, 1.5 stop, line kept low
    div = 16'd2; len = 2'd1; pen = 0; stp = 2'd1;
    c0 = got_cnt; send(8'h2B, 0, 3, 1);
    ticks(48);
    chk("R6 ferr flagged", got_fe, 1); chk("R6 data delivered", got_data, 8'h2B);
    chk("R7 no restart while low", got_cnt, c0 + 1);
    chk("R10 flags held", ferr, 1);
    rx = 1'b1; ticks(20);
    send(8'h15, 0, 3, 0); ticks(4);
    chk("R7 rearmed after high", got_data, 8'h15); chk("R7 ferr cleared", got_fe, 0);

    // false start: low for 4 ticks
    len = 2'd3; stp = 2'd0;
    c0 = got_cnt;
    @(posedge clk); #1; rx = 1'b0; ticks(4); rx = 1'b1; ticks(40);
    chk("R3 false start ignored", got_cnt, c0);
    chk("R3 data unchanged", data, 8'h15);
    send(8'h81, 0, 2, 0); ticks(4);
    chk("R3 next char ok", got_data, 8'h81);

    // back-to-back, one stop bit
    c0 = got_cnt;
    send(8'h3C, 0, 2, 0); send(8'hC3, 0, 2, 0); ticks(4);
    chk("R8 two chars", got_cnt, c0 + 2); chk("R8 second char", got_data, 8'hC3);

    // back-to-back, two stop bits, even parity
    stp = 2'd2; pen = 1; podd = 0;
    c0 = got_cnt;
    send(8'h7E, 0, 4, 0); send(8'h01, 0, 4, 0); ticks(4);
    chk("R8 two chars 2 stop", got_cnt, c0 + 2); chk("R8 data 2 stop", got_data, 8'h01);

    // too-short stop for 2-stop config: model covers timing
    pen = 0;
    send(8'h96, 0, 2, 0); send(8'h69, 0, 2, 0);
    rx = 1'b1; ticks(400);

    c0 = got_cnt; ticks(50);
    chk("R10 stable idle", got_cnt, c0);
    summary();
  end
endmodule